// File: doc/BRIEF.md
# In-Order Load Return Sequencer

This block sits beside the load/store pipe of an in-order integer core. It decides in which cycle each load hands its result to the integer register file. Loads enter one per cycle with a tag, an access size, a signedness flag, the low address bits and a data-cache hit indication. The block holds them in an in-order queue and sends back a single return-valid/tag pair per cycle. When a load is misaligned, the block raises a trap pulse instead of a return.

The timing follows a few rules:
- A hitting load normally returns two cycles after issue.
- Sign-extending loads narrower than a doubleword take one cycle more, and they switch on a sticky slow mode that also stretches loads issued back to back behind them.
- A load that missed waits for a fill-complete strobe from the miss path. Every younger load queues behind it, including loads that hit.

The load input is a valid/ready stream, and a transfer happens in any cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` falls while the queue holds its full depth of loads. While it is low, the values on the load inputs are ignored, and the source may keep or change them. The return and trap outputs carry no ready, because the register file accepts every return. `fill_done` is a plain strobe.

Top module: `load_return_seq`

## Requirements
- R1: A load accepted in cycle c that is aligned, hits, and is not a signed narrow load (a signed narrow load has `ld_signed`=1 and `ld_size` below 3) drives `ret_valid` with its tag in cycle c+2 when the queue is otherwise clear and slow mode is off. A signed doubleword counts as not narrow.
- R2: An aligned, hitting signed narrow load accepted in cycle c returns in cycle c+3.
- R3: Accepting an aligned signed narrow load turns slow mode on. Every load accepted while slow mode is on returns three cycles after issue. Slow mode stays on through consecutive accepting cycles, including a cycle whose load traps. It turns off after the first cycle that accepts no load.
- R4: Returns appear strictly in acceptance order. A miss that has not been filled holds back every younger load, hits included.
- R5: Each `fill_done` pulse in cycle f marks the oldest unfilled miss in the queue. That miss returns no earlier than cycle f+1 and no earlier than its own latency allows. The younger loads then drain one per cycle as they become due.
- R6: Size codes are 0 byte, 1 halfword, 2 word and 3 doubleword. A load is misaligned when `ld_addr_lo[0]` is set for a halfword, `ld_addr_lo[1:0]` is nonzero for a word, or `ld_addr_lo[2:0]` is nonzero for a doubleword. A misaligned load accepted in cycle c pulses `trap_valid` with its tag in cycle c+1 and never produces a return.
- R7: At most one return is produced per cycle.
- R8: `ld_ready` is low while 8 loads are pending. A load offered while `ld_ready` is low is not taken and never returns.
- R9: A `fill_done` pulse while no unfilled miss is queued has no effect. A miss accepted afterwards still waits for its own pulse.
- R10: After reset, `ld_ready` is high and `ret_valid` and `trap_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load is offered this cycle |
| ld_ready | output | 1 | Queue can take a load this cycle |
| ld_tag | input | TAG_W | Identifier of the offered load |
| ld_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 dword) |
| ld_signed | input | 1 | Load sign-extends its result |
| ld_addr_lo | input | 3 | Low three address bits |
| ld_hit | input | 1 | Load hit in the data cache |
| fill_done | input | 1 | Strobe: the oldest outstanding miss has its data |
| ret_valid | output | 1 | A load returns data to the register file this cycle |
| ret_tag | output | TAG_W | Tag of the returning load |
| trap_valid | output | 1 | Misalignment trap pulse |
| trap_tag | output | TAG_W | Tag of the trapping load |

## Verification
The bench targets the cycle just after a signed narrow load, where a fast younger load would collide with it on the single return path or overtake it. It also targets the cycle after an idle gap, where a design that never leaves slow mode would return late. Miss sequences with hits interleaved between two misses check that a fill goes to the oldest miss and that no hit slips past an unfilled one. A design that releases any miss, or lets hits bypass, returns tags out of order. A stray fill on an empty queue, a queue filled to its depth with a rejected ninth load, and misaligned loads of every size show whether spurious returns appear or a trap comes out in the wrong cycle.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ld_size_e;

  // Latency in cycles from acceptance to return for each load kind.
  localparam int FAST_LAT = 2;
  localparam int SLOW_LAT = FAST_LAT + 1;
endpackage

// File: rtl/lrs_classify.sv
module lrs_classify
  import lrs_pkg::*;
(
  input  logic [1:0] size,
  input  logic       sign_ext,
  input  logic [2:0] addr_lo,
  output logic       misaligned,
  output logic       narrow_signed
);
  ld_size_e sz;

  always_comb begin
    sz = ld_size_e'(size);
    unique case (sz)
      SZ_BYTE:  misaligned = 1'b0;
      SZ_HALF:  misaligned = addr_lo[0];
      SZ_WORD:  misaligned = |addr_lo[1:0];
      default:  misaligned = |addr_lo;
    endcase
    narrow_signed = sign_ext && (sz != SZ_DWORD);
  end
endmodule

// File: rtl/lrs_delay_mode.sv
module lrs_delay_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic set_req,
  output logic mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= 1'b0;
    else if (!fire) mode_q <= 1'b0;
    else if (set_req) mode_q <= 1'b1;
  end

  // R3: an idle cycle ends slow mode, a signed narrow load starts it
  p_mode_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !mode_q);
  p_mode_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && set_req) |=> mode_q);
endmodule

// File: rtl/lrs_order_queue.sv
module lrs_order_queue #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 6,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              push_miss,
  input  logic [WAIT_W-1:0] push_wait,
  input  logic              fill,
  output logic              full,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [WAIT_W-1:0] wait_q [DEPTH];
  logic [DEPTH-1:0]  miss_q;
  logic [DEPTH-1:0]  done_q;
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;

  logic             pop;
  logic             fill_hit;
  logic [PTR_W-1:0] fill_idx;

  assign full      = (count_q == CNT_W'(DEPTH));
  assign ret_valid = (count_q != '0) && (wait_q[head_q] == '0) &&
                     (!miss_q[head_q] || done_q[head_q]);
  assign ret_tag   = tag_q[head_q];
  assign pop       = ret_valid;

  // Oldest queued miss that has not yet been filled.
  always_comb begin
    fill_hit = 1'b0;
    fill_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!fill_hit && (i < int'(count_q))) begin
        if (miss_q[PTR_W'((int'(head_q) + i) % DEPTH)] &&
            !done_q[PTR_W'((int'(head_q) + i) % DEPTH)]) begin
          fill_hit = 1'b1;
          fill_idx = PTR_W'((int'(head_q) + i) % DEPTH);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= '0;
        wait_q[i] <= '0;
      end
      miss_q  <= '0;
      done_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wait_q[i] != '0) wait_q[i] <= wait_q[i] - 1'b1;
        if (fill && fill_hit && (fill_idx == PTR_W'(i))) done_q[i] <= 1'b1;
        if (push && (tail_q == PTR_W'(i))) begin
          tag_q[i]  <= push_tag;
          wait_q[i] <= push_wait;
          miss_q[i] <= push_miss;
          done_q[i] <= 1'b0;
        end
      end
      if (push) tail_q <= (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
      if (pop)  head_q <= (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // R8: the issue side never writes into a full queue
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R1: a return needs an entry that was present one cycle earlier
  p_ret_has_age_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(count_q != '0));
  // R7: occupancy drops by at most one per cycle
  p_one_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> (count_q == $past(count_q)) || (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/load_return_seq.sv
module load_return_seq
  import lrs_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [1:0]       ld_size,
  input  logic             ld_signed,
  input  logic [2:0]       ld_addr_lo,
  input  logic             ld_hit,
  input  logic             fill_done,
  output logic             ret_valid,
  output logic [TAG_W-1:0] ret_tag,
  output logic             trap_valid,
  output logic [TAG_W-1:0] trap_tag
);
  localparam int WAIT_W = $clog2(SLOW_LAT);

  logic              fire, misal, nsigned, slow_mode, q_full, slow;
  logic [WAIT_W-1:0] wait_init;

  assign ld_ready  = !q_full;
  assign fire      = ld_valid && ld_ready;
  assign slow      = nsigned || slow_mode;
  assign wait_init = slow ? WAIT_W'(SLOW_LAT - 1) : WAIT_W'(FAST_LAT - 1);

  lrs_classify u_cls (
    .size          (ld_size),
    .sign_ext      (ld_signed),
    .addr_lo       (ld_addr_lo),
    .misaligned    (misal),
    .narrow_signed (nsigned)
  );

  lrs_delay_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .set_req (nsigned && !misal),
    .mode_q  (slow_mode)
  );

  lrs_order_queue #(
    .DEPTH  (DEPTH),
    .TAG_W  (TAG_W),
    .WAIT_W (WAIT_W)
  ) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fire && !misal),
    .push_tag  (ld_tag),
    .push_miss (!ld_hit),
    .push_wait (wait_init),
    .fill      (fill_done),
    .full      (q_full),
    .ret_valid (ret_valid),
    .ret_tag   (ret_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_tag   <= '0;
    end else begin
      trap_valid <= fire && misal;
      if (fire && misal) trap_tag <= ld_tag;
    end
  end

  // R6: every trap follows an accepted misaligned load
  p_trap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(fire && misal));
  // R8: nothing is accepted while the queue reports full
  p_ready_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !fire);
endmodule

// File: tb/sim_load_return_seq.sv
`timescale 1ns/1ps
module sim_load_return_seq;
  localparam int TAG_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, ld_signed = 0, ld_hit = 0, fill_done = 0;
  logic [TAG_W-1:0] ld_tag = '0;
  logic [1:0] ld_size = '0;
  logic [2:0] ld_addr_lo = '0;
  logic ld_ready, ret_valid, trap_valid;
  logic [TAG_W-1:0] ret_tag, trap_tag;

  load_return_seq #(.TAG_W(TAG_W), .DEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_tag(ld_tag), .ld_size(ld_size), .ld_signed(ld_signed),
    .ld_addr_lo(ld_addr_lo), .ld_hit(ld_hit), .fill_done(fill_done),
    .ret_valid(ret_valid), .ret_tag(ret_tag),
    .trap_valid(trap_valid), .trap_tag(trap_tag));

  always #5 clk = ~clk;

  typedef struct { int tag; int elig; bit miss; bit filled; } pend_t;
  pend_t mq[$];
  int cyc = 0, tests = 0, fails = 0;
  int exp_trap_at = -1, exp_trap_tag = 0;
  bit bmode = 0, done = 0;
  string cur_req = "R10";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit misal_f(input int sz, input int a);
    case (sz)
      0: return 0;
      1: return (a & 1) != 0;
      2: return (a & 3) != 0;
      default: return (a & 7) != 0;
    endcase
  endfunction

  // Driver: presents one cycle of stimulus and updates the expectation model.
  task automatic drive(input bit v, input int tag, input int sz, input bit sg,
                       input int a, input bit hit, input bit fl);
    bit acc, mis, sn;
    ld_valid = v; ld_tag = TAG_W'(tag); ld_size = 2'(sz); ld_signed = sg;
    ld_addr_lo = 3'(a); ld_hit = hit; fill_done = fl;
    acc = v && ld_ready;
    if (fl) begin
      for (int i = 0; i < mq.size(); i++) begin
        if (mq[i].miss && !mq[i].filled) begin
          mq[i].filled = 1;
          if (mq[i].elig < cyc + 1) mq[i].elig = cyc + 1;
          break;
        end
      end
    end
    if (acc) begin
      mis = misal_f(sz, a);
      sn  = sg && (sz != 3);
      if (mis) begin
        exp_trap_at = cyc + 1; exp_trap_tag = tag;
      end else begin
        mq.push_back('{tag: tag, elig: cyc + ((sn || bmode) ? 3 : 2),
                       miss: !hit, filled: 0});
      end
      bmode = bmode | (sn && !mis);
    end else begin
      bmode = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 1, 0);
  endtask

  // Monitor: pops the expected return order and compares each cycle.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit er, et;
      er = (mq.size() > 0) && (mq[0].elig <= cyc) && (!mq[0].miss || mq[0].filled);
      tests++;
      if (ret_valid !== er || (er && ret_tag !== TAG_W'(mq[0].tag))) begin
        fails++;
        $display("FAIL %s ret cyc=%0d: got valid=%0b tag=%0d, expected valid=%0b tag=%0d",
                 cur_req, cyc, ret_valid, ret_tag, er, er ? mq[0].tag : 0);
      end
      if (er) void'(mq.pop_front());
      et = (exp_trap_at == cyc);
      tests++;
      if (trap_valid !== et || (et && trap_tag !== TAG_W'(exp_trap_tag))) begin
        fails++;
        $display("FAIL R6 trap cyc=%0d: got valid=%0b tag=%0d, expected valid=%0b tag=%0d",
                 cyc, trap_valid, trap_tag, et, exp_trap_tag);
      end
    end
  end

  task automatic check(input string req, input bit got, input bit exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 ready", ld_ready, 1);
    check("R10 ret", ret_valid, 0);
    check("R10 trap", trap_valid, 0);
    rst_n = 1;

    cur_req = "R1";
    drive(1, 1, 2, 0, 0, 1, 0); idle(4);
    drive(1, 2, 3, 1, 0, 1, 0); idle(4);
    cur_req = "R2";
    drive(1, 3, 0, 1, 3, 1, 0); idle(4);
    cur_req = "R3";
    drive(1, 4, 1, 1, 2, 1, 0);
    drive(1, 5, 2, 0, 0, 1, 0);
    drive(1, 6, 3, 0, 0, 1, 0);
    idle(1);
    drive(1, 7, 2, 0, 4, 1, 0); idle(5);
    cur_req = "R4";
    drive(1, 8, 3, 0, 0, 0, 0);
    drive(1, 9, 2, 0, 0, 1, 0);
    drive(1, 10, 0, 0, 1, 1, 0);
    idle(3);
    cur_req = "R5";
    drive(0, 0, 0, 0, 0, 1, 1); idle(5);
    drive(1, 11, 3, 0, 0, 0, 0);
    drive(1, 12, 2, 0, 0, 1, 0);
    drive(1, 13, 1, 1, 0, 0, 0);
    drive(1, 14, 0, 0, 0, 1, 0);
    idle(2); drive(0, 0, 0, 0, 0, 1, 1);
    idle(2); drive(0, 0, 0, 0, 0, 1, 1); idle(4);
    cur_req = "R9";
    drive(0, 0, 0, 0, 0, 1, 1);
    drive(1, 15, 2, 0, 0, 0, 0); idle(4);
    drive(0, 0, 0, 0, 0, 1, 1); idle(3);
    cur_req = "R6";
    drive(1, 16, 1, 0, 1, 1, 0);
    drive(1, 17, 3, 0, 4, 1, 0);
    drive(1, 18, 0, 1, 7, 1, 0);
    drive(1, 19, 2, 0, 2, 0, 0);
    idle(4);
    cur_req = "R8";
    for (int i = 0; i < 8; i++) drive(1, 20 + i, 3, 0, 0, 0, 0);
    check("R8 ready low when full", ld_ready, 0);
    drive(1, 28, 2, 0, 0, 1, 0);
    check("R8 still not ready", ld_ready, 0);
    for (int i = 0; i < 8; i++) drive(0, 0, 0, 0, 0, 1, 1);
    idle(4);
    check("R8 ready after drain", ld_ready, 1);
    cur_req = "R7";
    for (int i = 0; i < 4; i++) drive(1, 30 + i, 2, 0, 0, 1, 0);
    idle(4);
    cur_req = "R4 mixed";
    for (int i = 0; i < 60; i++)
      drive((i % 5) != 4, (i + 40) % 64, i % 4, (i % 3) == 0,
            (i % 7 == 0) ? 1 : 0, (i % 9) != 0, (i % 6) == 5);
    for (int i = 0; i < 10; i++) drive(0, 0, 0, 0, 0, 1, 1);
    idle(4);
    check("R4 all returned", mq.size() == 0, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule